// File: doc/BRIEF.md
# Line-Driver Power Alarm and Line-State Override

This block guards a subscriber line driver against overheating. Each power sample first passes through a first-order thermal low-pass filter. The filter's pole is programmable. The filtered value is then compared with a programmable limit for its channel. The block works in one of two modes. In discrete mode, six channels each carry the dissipation estimate of one output transistor. In integrated-driver mode, only channel 0 matters, and it carries the total dissipation of the driver package. The power codes carry a different weight in each mode: 498 µW per step in discrete mode and 1059.6 µW per step in integrated mode. The host does the conversion from watts to codes. For example, a 1 W limit in integrated mode is code 0x3B0.

Any alarm sets a sticky status bit. An alarm also forces the effective line state to OPEN (code 0), whatever the interrupt enables say. The line stays OPEN until the host writes a fresh line state. If an alarm arrives in the same cycle as a host write, the alarm wins. The interrupt output is the OR of the enabled status bits.

Registers are written through a write strobe. The address map is: 0 interrupt enable, 1 status (write one to clear), 2 filter pole, and 4 through 4+NCH-1 the per-channel limits. On every clock where `sample_vld` is high, the filter updates as follows: acc += ((sample − acc) · pole) >>> FILT_SHIFT. The result saturates to the range [0, 2^SMP_W − 1].

Top module: `pwr_guard`

## Requirements
- R1: After reset, `line_state` is OPEN (0), `alarm_status` is 0 and `irq` is 0. Limits reset to all ones, the pole resets to 0, and the enables reset to 0.
- R2: When no alarm is present, a pulse on `state_wr` makes `line_state` equal to `state_req` one clock later.
- R3: In discrete mode, a channel raises an alarm when its filtered value is strictly greater than its limit. A value equal to the limit raises no alarm. An alarm on channel i sets status bit i and drives `line_state` to OPEN one clock after the filter update.
- R4: The forced OPEN state survives the return of the filtered power below the limit. It ends only with a host state write.
- R5: The forced OPEN state and the status bit occur even when the channel's interrupt enable bit is 0.
- R6: `irq` is high exactly when some status bit and its enable bit are both 1.
- R7: Writing register 1 clears the status bits where the written data has a 1. Bits written with 0 keep their value.
- R8: In integrated-driver mode (`mode_integrated`=1), only channel 0 can raise an alarm, and it reports on status bit 0. Channels 1–5 set no bit and do not force OPEN.
- R9: A host state write in the same cycle as an active alarm is overridden, and `line_state` stays OPEN.
- R10: With pole P, each valid sample moves the filter by ((sample − acc)·P) >>> FILT_SHIFT. With P = 2^FILT_SHIFT the filter tracks the sample exactly. With P = 2^(FILT_SHIFT−1), a step from 0 to 1000 gives 500 and then 750.
- R11: The filter saturates. An overshooting pole clamps the result at 2^SMP_W − 1 going up and at 0 going down, with no wraparound.
- R12: While `sample_vld` is low, the filters hold their value regardless of the sample inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_integrated | input | 1 | 1 selects the single total-power channel |
| sample_vld | input | 1 | Filter update enable |
| samples | input | NCH*SMP_W | Power codes, channel i at bits [i*SMP_W +: SMP_W] |
| state_wr | input | 1 | Host line-state write strobe |
| state_req | input | 3 | Requested line state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| line_state | output | 3 | Effective line state (0 = OPEN) |
| alarm_status | output | NCH | Sticky alarm status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: six channels, 16-bit samples and pole, and a filter shift of 12. With these values, a pole of 4096 makes the filter follow the input in one step. This lets the alarm compare at the exact limit be probed directly. A pole of 2048 gives an easy halving sequence for checking the filter arithmetic. A pole of 0xFFFF overshoots by roughly sixteen times, which drives the sum both above the 16-bit maximum and below zero, so both saturation bounds are exercised.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  localparam int LS_W = 3;
  typedef logic [LS_W-1:0] line_state_t;
  localparam line_state_t LS_OPEN = '0;

  localparam int REG_EN   = 0;
  localparam int REG_STAT = 1;
  localparam int REG_POLE = 2;
  localparam int REG_THR0 = 4;
endpackage

// File: rtl/pg_thermal_filter.sv
module pg_thermal_filter #(
  parameter int SMP_W      = 16,
  parameter int POLE_W     = 16,
  parameter int FILT_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [SMP_W-1:0]  sample,
  input  logic [POLE_W-1:0] pole,
  output logic [SMP_W-1:0]  filt
);
  localparam int DIFF_W = SMP_W + 1;
  localparam int PROD_W = SMP_W + POLE_W + 2;
  localparam logic signed [PROD_W-1:0] TOP_V = {{(PROD_W-SMP_W){1'b0}}, {SMP_W{1'b1}}};

  logic [SMP_W-1:0]         acc_q, acc_d;
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod, step, sum;

  always_comb begin
    diff = $signed({1'b0, sample}) - $signed({1'b0, acc_q});
    prod = PROD_W'(diff) * $signed(PROD_W'({1'b0, pole}));
    step = prod >>> FILT_SHIFT;
    sum  = step + $signed(PROD_W'({1'b0, acc_q}));
    acc_d = acc_q;
    if (vld) begin
      if (sum < 0)          acc_d = '0;
      else if (sum > TOP_V) acc_d = '1;
      else                  acc_d = sum[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign filt = acc_q;

  // R12: no update without a valid sample
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(filt));
  // R10: a pole of zero leaves the filter untouched
  a_r10_zero_pole: assert property (@(posedge clk) disable iff (!rst_n)
    (pole == '0) |=> $stable(filt));
endmodule

// File: rtl/pg_alarm_core.sv
module pg_alarm_core #(
  parameter int NCH   = 6,
  parameter int SMP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_int,
  input  logic [NCH*SMP_W-1:0] filt,
  input  logic [NCH*SMP_W-1:0] thr,
  input  logic                 en_wr,
  input  logic                 stat_wr,
  input  logic [NCH-1:0]       wdata,
  output logic [NCH-1:0]       status,
  output logic                 irq,
  output logic                 any_alarm
);
  logic [NCH-1:0] raw, qual;
  logic [NCH-1:0] stat_q, stat_d, en_q, en_d, clr;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign raw[i] = filt[i*SMP_W +: SMP_W] > thr[i*SMP_W +: SMP_W];
  end

  always_comb begin
    qual      = mode_int ? {{(NCH-1){1'b0}}, raw[0]} : raw;
    any_alarm = |qual;
    clr       = stat_wr ? wdata : '0;
    stat_d    = (stat_q & ~clr) | qual;
    en_d      = en_wr ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign status = stat_q;
  assign irq    = |(stat_q & en_q);

  // R7: a bit only falls through an explicit clear write
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status)));
  // R8: integrated mode never raises the upper bits
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    mode_int |=> ((status[NCH-1:1] & ~$past(status[NCH-1:1])) == '0));
  // R3: a raised alarm is always recorded
  a_r3_record: assert property (@(posedge clk) disable iff (!rst_n)
    any_alarm |=> (status != '0));
endmodule

// File: rtl/pg_line_ctrl.sv
module pg_line_ctrl
  import pwr_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        any_alarm,
  input  logic        state_wr,
  input  line_state_t state_req,
  output line_state_t line_state
);
  logic        force_q, force_d;
  line_state_t req_q, req_d;

  always_comb begin
    req_d   = state_wr ? state_req : req_q;
    force_d = force_q;
    if (any_alarm)     force_d = 1'b1;
    else if (state_wr) force_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= LS_OPEN;
      force_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      force_q <= force_d;
    end
  end

  assign line_state = force_q ? LS_OPEN : req_q;

  // R3 / R5 / R9: an alarm always yields OPEN next cycle
  a_r3_force_open: assert property (@(posedge clk) disable iff (!rst_n)
    any_alarm |=> (line_state == LS_OPEN));
  // R2: an uncontested host write takes effect
  a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
    (state_wr && !any_alarm) |=> (line_state == $past(state_req)));
  // R4: forced OPEN persists without a host write
  a_r4_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && !state_wr) |=> (line_state == LS_OPEN));
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int SMP_W      = 16,
  parameter int POLE_W     = 16,
  parameter int FILT_SHIFT = 12,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_integrated,
  input  logic                      sample_vld,
  input  logic [NCH*SMP_W-1:0]      samples,
  input  logic                      state_wr,
  input  logic [LS_W-1:0]           state_req,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [LS_W-1:0]           line_state,
  output logic [NCH-1:0]            alarm_status,
  output logic                      irq
);
  logic [1:0]            rst_sync;
  logic                  rst_i_n;
  logic [POLE_W-1:0]     pole_q, pole_d;
  logic [NCH*SMP_W-1:0]  thr, filt;
  logic                  en_wr, stat_wr, pole_wr, any_alarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign en_wr   = reg_wr && (reg_addr == ADDR_W'(REG_EN));
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(REG_STAT));
  assign pole_wr = reg_wr && (reg_addr == ADDR_W'(REG_POLE));

  always_comb pole_d = pole_wr ? reg_wdata[POLE_W-1:0] : pole_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pole_q <= '0;
    else          pole_q <= pole_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             thr_wr;
    logic [SMP_W-1:0] thr_q, thr_d;

    assign thr_wr = reg_wr && (reg_addr == ADDR_W'(REG_THR0 + i));
    always_comb thr_d = thr_wr ? reg_wdata[SMP_W-1:0] : thr_q;

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) thr_q <= '1;
      else          thr_q <= thr_d;
    end
    assign thr[i*SMP_W +: SMP_W] = thr_q;

    pg_thermal_filter #(
      .SMP_W(SMP_W), .POLE_W(POLE_W), .FILT_SHIFT(FILT_SHIFT)
    ) u_filt (
      .clk(clk), .rst_n(rst_i_n), .vld(sample_vld),
      .sample(samples[i*SMP_W +: SMP_W]), .pole(pole_q),
      .filt(filt[i*SMP_W +: SMP_W])
    );
  end

  pg_alarm_core #(.NCH(NCH), .SMP_W(SMP_W)) u_alarm (
    .clk(clk), .rst_n(rst_i_n), .mode_int(mode_integrated),
    .filt(filt), .thr(thr), .en_wr(en_wr), .stat_wr(stat_wr),
    .wdata(reg_wdata[NCH-1:0]), .status(alarm_status),
    .irq(irq), .any_alarm(any_alarm)
  );

  pg_line_ctrl u_line (
    .clk(clk), .rst_n(rst_i_n), .any_alarm(any_alarm),
    .state_wr(state_wr), .state_req(state_req), .line_state(line_state)
  );

  // R6: interrupt needs a recorded alarm
  a_r6_irq_src: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (alarm_status != '0));
endmodule

// File: tb/pwr_guard_test.sv
module pwr_guard_test;
  localparam int CLK_P = 10;
  localparam int NCH = 6;
  localparam int SW  = 16;

  logic clk = 1'b0;
  logic rst_n, mode_integrated, sample_vld, state_wr, reg_wr, irq;
  logic [NCH*SW-1:0] samples;
  logic [2:0] state_req, line_state;
  logic [3:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [NCH-1:0] alarm_status;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_guard uut (
    .clk(clk), .rst_n(rst_n), .mode_integrated(mode_integrated),
    .sample_vld(sample_vld), .samples(samples), .state_wr(state_wr),
    .state_req(state_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .line_state(line_state),
    .alarm_status(alarm_status), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host(input int s);
    @(negedge clk); state_wr = 1'b1; state_req = 3'(s);
    @(negedge clk); state_wr = 1'b0;
  endtask

  task automatic feed_all(input int v0, input int vr);
    @(negedge clk); sample_vld = 1'b1;
    for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = 16'(i == 0 ? v0 : vr);
    @(negedge clk); sample_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic feed_ch(input int ch, input int v);
    @(negedge clk); sample_vld = 1'b1;
    for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = 16'(i == ch ? v : 0);
    @(negedge clk); sample_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic recover();
    pwr_set(4096);
    feed_all(0, 0);
    wr(1, 'h3F);
    host(2);
  endtask

  task automatic pwr_set(input int p); wr(2, p); endtask

  task automatic t_reset();
    check("R1 line", int'(line_state), 0);
    check("R1 status", int'(alarm_status), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_host();
    pwr_set(4096);
    for (int i = 0; i < NCH; i++) wr(4 + i, 1000);
    wr(0, 'h3F);
    host(5);
    check("R2 host state", int'(line_state), 5);
  endtask

  task automatic t_strict();
    feed_all(1000, 1000);
    check("R3 equal no alarm", int'(alarm_status), 0);
    check("R3 equal keeps state", int'(line_state), 5);
    feed_ch(3, 1001);
    check("R3 status bit", int'(alarm_status), 8);
    check("R3 forced open", int'(line_state), 0);
    check("R6 irq on", int'(irq), 1);
  endtask

  task automatic t_persist();
    feed_all(0, 0);
    check("R4 still open", int'(line_state), 0);
    wr(1, 'h01);
    check("R7 zero bits kept", int'(alarm_status), 8);
    wr(1, 'h08);
    check("R7 cleared", int'(alarm_status), 0);
    check("R6 irq off", int'(irq), 0);
    check("R4 still open after clear", int'(line_state), 0);
    host(2);
    check("R4 released", int'(line_state), 2);
  endtask

  task automatic t_masked();
    wr(0, 0);
    feed_ch(0, 2000);
    check("R5 open while masked", int'(line_state), 0);
    check("R5 status while masked", int'(alarm_status), 1);
    check("R6 irq masked", int'(irq), 0);
    wr(0, 1);
    check("R6 irq enabled", int'(irq), 1);
    recover();
    check("R4 recovered", int'(line_state), 2);
  endtask

  task automatic t_collide();
    @(negedge clk); sample_vld = 1'b1;
    for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = 16'(i == 1 ? 3000 : 0);
    @(negedge clk); sample_vld = 1'b0; state_wr = 1'b1; state_req = 3'd6;
    @(negedge clk); state_wr = 1'b0;
    check("R9 alarm wins", int'(line_state), 0);
    recover();
  endtask

  task automatic t_integrated();
    mode_integrated = 1'b1;
    feed_all(0, 5000);
    check("R8 upper ignored status", int'(alarm_status), 0);
    check("R8 upper ignored line", int'(line_state), 2);
    feed_all(1001, 5000);
    check("R8 total alarm", int'(alarm_status), 1);
    check("R8 total forces open", int'(line_state), 0);
    feed_all(0, 0);
    mode_integrated = 1'b0;
    recover();
  endtask

  task automatic t_filter();
    wr(4, 749);
    pwr_set(2048);
    feed_ch(0, 1000);
    check("R10 first step 500", int'(alarm_status), 0);
    feed_ch(0, 1000);
    check("R10 second step 750", int'(alarm_status), 1);
    recover();
    wr(4, 100);
    @(negedge clk); sample_vld = 1'b0; samples = '0; samples[SW-1:0] = 16'd500;
    repeat (3) @(negedge clk);
    check("R12 hold without valid", int'(alarm_status), 0);
    check("R12 line unchanged", int'(line_state), 2);
  endtask

  task automatic t_sat();
    wr(4, 'hFFFE);
    pwr_set('hFFFF);
    feed_ch(0, 'hFFFF);
    check("R11 upper clamp", int'(alarm_status), 1);
    feed_ch(0, 0);
    wr(4, 0);
    wr(1, 'h3F);
    host(3);
    check("R11 lower clamp status", int'(alarm_status), 0);
    check("R11 lower clamp line", int'(line_state), 3);
  endtask

  initial begin
    rst_n = 1'b0; mode_integrated = 1'b0; sample_vld = 1'b0; samples = '0;
    state_wr = 1'b0; state_req = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_host();
    t_strict();
    t_persist();
    t_masked();
    t_collide();
    t_integrated();
    t_filter();
    t_sat();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule